// File: doc/BRIEF.md
# Period-Integrating Frequency Meter

This block measures the frequency of a slow, clock-like pulse input against a fast reference clock. It counts reference cycles across a window of 1, 4 or 16 input periods. A sequential divider then turns that count into a 32-bit binary frequency word. A two-bit range selection sets two things: the length of the window and the decimal unit of the result, which is millihertz, centihertz, decihertz or hertz.

Software reaches the block through a control byte, a status byte and a 16-bit data word. A range change is a request and acknowledge exchange: the status byte shows the new range only when the first result measured in that range has been written. A second exchange loads a new no-signal timeout in milliseconds. If no rising edge arrives within that timeout, the result is forced to zero and measurement starts again on the next edge. A hold input freezes the result and refuses range changes. Results above the 10 kHz ceiling of a range read as all ones.

Top module: `period_freq_meter`

## Requirements
- R1: After reset `freq_word` is 0 and `status_byte` is 0x20 while `hold_en` is low: range acknowledge 00, timeout acknowledge 0. The no-signal timeout is WD_DEFAULT_MS milliseconds.
- R2: With range 00 (`ctrl_byte[1:0]`) the window is one input period and `freq_word` = floor(1000*CLK_HZ / T), where T is the input period in reference cycles. `sig_in` is asynchronous, passes a two flip-flop synchroniser, and each rising edge is counted exactly once.
- R3: Range 01 integrates 4 periods with scale 100, range 10 integrates 16 periods with scale 10, and range 11 integrates 16 periods with scale 1. In each case `freq_word` = floor(S*N*CLK_HZ / (N*T)).
- R4: After a new range is requested, `status_byte[1:0]` and `freq_word` keep their previous values until the first result measured in the new range is written. At that point both update together.
- R5: While `hold_en` is 1, `freq_word` and `status_byte[1:0]` do not change and range requests are not taken. `status_byte[5]` reads 0 while `hold_en` is 1 and 1 otherwise.
- R6: A result above MAX_HZ*S reads 0xFFFFFFFF. A result exactly equal to MAX_HZ*S is reported unchanged.
- R7: If no synchronised rising edge occurs for the timeout, `freq_word` becomes 0. The next rising edge starts a new measurement.
- R8: Setting `ctrl_byte[4]` requests a timeout load. The value is latched at the first clock edge that sees the bit set. `status_byte[4]` is set at the following edge and is cleared at the first edge where `ctrl_byte[4]` is 0. So `status_byte[4]` is 1 exactly when the bit was set at this edge and the one before.
- R9: The loaded timeout is `wd_data[13:0]` milliseconds; bits 15:14 are ignored. One millisecond is CLK_HZ/1000 reference cycles.
- R10: `status_byte` bits 7:6 and 3:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous pulse input being measured |
| hold_en | input | 1 | Freezes the result and blocks range changes when high |
| ctrl_byte | input | 8 | Bit 4 timeout load request, bits 1:0 requested range |
| wd_data | input | 16 | Timeout in ms, taken on a load request (bits 13:0 used) |
| status_byte | output | 8 | Bit 5 hold state (0 = held), bit 4 timeout acknowledge, bits 1:0 acknowledged range |
| freq_word | output | 32 | Measured frequency in the unit of the acknowledged range |

## Verification
The bench sweeps all four ranges with input periods whose quotients have remainders. A wrong window length or unit scale therefore shows up as an exact mismatch. Range changes are probed a few cycles after the request, which exposes an acknowledge that moves before real data exists. The bench also tests the over-range boundary at exactly 10 kHz and just above it, so an off-by-one comparison either flags a legal maximum or passes an illegal one. Timeout loads use a value with the top two bits set: a missing mask leaves a timeout of tens of seconds that never fires. Hold is driven while the input period and the range request both change, so any leak through the freeze is caught on the next clock.

// File: rtl/fm_pkg.sv
// Shared definitions for the period-integrating frequency meter.
// Assumes range codes 0..3 as listed in the brief.
package fm_pkg;

    // Measurement window state: waiting for a starting edge, or integrating.
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_e;

    localparam int unsigned TMO_W = 14;

    // Number of input periods integrated for a range code.
    function automatic int unsigned win_periods(input logic [1:0] rng);
        case (rng)
            2'd0:    return 1;
            2'd1:    return 4;
            default: return 16;
        endcase
    endfunction

    // Units per hertz of the reported value for a range code.
    function automatic int unsigned unit_scale(input logic [1:0] rng);
        case (rng)
            2'd0:    return 1000;
            2'd1:    return 100;
            2'd2:    return 10;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/fm_sync_edge.sv
// Synchroniser and rising-edge detector for the asynchronous pulse input.
// Assumes the input stays at each level for more than two reference cycles.
// rise_pulse is high for one cycle per rising edge of the synchronised input.
module fm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise_pulse
);

    logic [STAGES:0] pipe_q;

    // Shift the raw input through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], raw_in};
    end

    assign rise_pulse = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R2: each rising edge yields a single pulse
    a_r2_one_pulse_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/fm_tick_wd.sv
// Millisecond prescaler and no-signal watchdog.
// Counts whole milliseconds since the last synchronised rising edge and pulses
// expire once when the count reaches the programmed timeout. The timeout is
// loaded from load_val when load_en is high; it resets to DEFAULT_MS.
module fm_tick_wd #(
    parameter int unsigned TICK_CYC   = 1000,
    parameter int unsigned DEFAULT_MS = 10000,
    parameter int unsigned TMO_W      = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    input  logic             load_en,
    input  logic [TMO_W-1:0] load_val,
    output logic             expire
);

    localparam int unsigned PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(DEFAULT_MS);

    logic [PW-1:0]    presc_q;
    logic             tick;
    logic [TMO_W-1:0] tmo_q;
    logic [TMO_W:0]   ms_q;
    logic [TMO_W:0]   ms_inc;
    logic             fired_q;

    assign tick   = (presc_q == PW'(TICK_CYC - 1));
    assign ms_inc = ms_q + 1'b1;
    assign expire = tick && !fired_q && !edge_seen && (ms_inc >= {1'b0, tmo_q});

    // Free-running prescaler producing one tick per millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= tick ? '0 : presc_q + 1'b1;
    end

    // Timeout register, replaced on a load request.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmo_q <= TMO_RST;
        else if (load_en) tmo_q <= load_val;
    end

    // Millisecond count since the last edge, with a one-shot expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_q    <= '0;
            fired_q <= 1'b0;
        end else if (edge_seen) begin
            ms_q    <= '0;
            fired_q <= 1'b0;
        end else if (tick && !fired_q) begin
            ms_q    <= ms_inc;
            fired_q <= expire;
        end
    end

    // R7: one expiry per silent stretch
    a_r7_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R9: a load places the requested value in the timeout register
    a_r9_timeout_taken: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (tmo_q == $past(load_val)));

endmodule

// File: rtl/fm_divider.sv
// Restoring sequential divider: one quotient bit per cycle, NUM_W cycles.
// Assumes start is raised only while busy is low. quot is final in the cycle
// done is high and stays until the next start.
module fm_divider #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic [DEN_W:0]    trial;
    logic              fits;

    assign trial = {rem_q, quot[NUM_W-1]};
    assign fits  = trial >= {1'b0, den_q};

    // Load operands on start, then shift-subtract one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quot   <= '0;
            step_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quot   <= num;
                den_q  <= den;
                rem_q  <= '0;
                step_q <= STEP_W'(NUM_W);
                busy   <= 1'b1;
            end else if (busy) begin
                rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                quot   <= {quot[NUM_W-2:0], fits};
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R2: the window logic never restarts a division in flight
    a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/period_freq_meter.sv
// Period-integrating frequency meter, top level.
// Integrates reference cycles over 1/4/16 input periods, divides a per-range
// constant by the count and reports the frequency in the unit of the range.
// Assumes CLK_HZ is a multiple of 1000 and MAX_HZ*1000 fits in 32 bits.
module period_freq_meter #(
    parameter int unsigned CLK_HZ        = 1_000_000,
    parameter int unsigned MAX_HZ        = 10_000,
    parameter int unsigned WD_DEFAULT_MS = 10_000,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned NUM_W         = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sig_in,
    input  logic        hold_en,
    input  logic [7:0]  ctrl_byte,
    input  logic [15:0] wd_data,
    output logic [7:0]  status_byte,
    output logic [31:0] freq_word
);
    import fm_pkg::*;

    localparam int unsigned TICK_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int unsigned PER_W    = 4;

    logic             rise;
    logic             expire;
    logic             tvd_req;
    logic             tvd_load;
    logic             tvd_load_q;
    logic             tvd_ack_q;
    logic [1:0]       meas_rng;
    logic [1:0]       ack_rng;
    logic [1:0]       div_rng;
    win_state_e       win_st;
    logic [PER_W-1:0] per_cnt;
    logic [CNT_W-1:0] cyc_cnt;
    logic             range_change;
    logic             win_end;
    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [NUM_W-1:0] div_num;
    logic [NUM_W-1:0] div_quot;
    logic [NUM_W-1:0] res_limit;
    logic             over;
    logic             discard_q;
    logic [31:0]      freq_q;
    logic             ctrl_unused;

    assign ctrl_unused = ^{ctrl_byte[7:5], ctrl_byte[3:2], wd_data[15:14]};

    fm_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (sig_in),
        .rise_pulse (rise)
    );

    fm_tick_wd #(
        .TICK_CYC   (TICK_CYC),
        .DEFAULT_MS (WD_DEFAULT_MS),
        .TMO_W      (TMO_W)
    ) i_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (rise),
        .load_en   (tvd_load),
        .load_val  (wd_data[TMO_W-1:0]),
        .expire    (expire)
    );

    fm_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (cyc_cnt),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    // Decode of requests and window completion.
    assign tvd_req      = ctrl_byte[4];
    assign range_change = !hold_en && (ctrl_byte[1:0] != meas_rng);
    assign win_end      = (win_st == WIN_RUN) && rise &&
                          (per_cnt == PER_W'(win_periods(meas_rng) - 1));
    assign div_start    = win_end && !range_change && !div_busy;
    assign div_num      = NUM_W'(64'(unit_scale(meas_rng)) * 64'(win_periods(meas_rng)) * 64'(CLK_HZ));
    assign res_limit    = NUM_W'(64'(MAX_HZ) * 64'(unit_scale(div_rng)));
    assign over         = div_quot > res_limit;

    // Window sequencer: take a new range, restart on expiry, count periods and cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_st   <= WIN_IDLE;
            per_cnt  <= '0;
            cyc_cnt  <= '0;
            meas_rng <= 2'd0;
        end else if (range_change) begin
            meas_rng <= ctrl_byte[1:0];
            win_st   <= WIN_IDLE;
        end else if (expire) begin
            win_st <= WIN_IDLE;
        end else if (win_st == WIN_IDLE) begin
            if (rise) begin
                win_st  <= WIN_RUN;
                per_cnt <= '0;
                cyc_cnt <= CNT_W'(1);
            end
        end else begin
            cyc_cnt <= (cyc_cnt == '1) ? cyc_cnt : cyc_cnt + 1'b1;
            if (win_end) begin
                per_cnt <= '0;
                cyc_cnt <= CNT_W'(1);
            end else if (rise) begin
                per_cnt <= per_cnt + 1'b1;
            end
        end
    end

    // Tag each division with its range; mark it stale if the window was abandoned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_rng   <= 2'd0;
            discard_q <= 1'b0;
        end else if (div_start) begin
            div_rng   <= meas_rng;
            discard_q <= 1'b0;
        end else if ((range_change || expire) && div_busy) begin
            discard_q <= 1'b1;
        end
    end

    // Result register and range acknowledge, both frozen while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q  <= '0;
            ack_rng <= 2'd0;
        end else if (!hold_en) begin
            if (div_done && !discard_q) begin
                freq_q  <= over ? '1 : div_quot[31:0];
                ack_rng <= div_rng;
            end else if (expire) begin
                freq_q  <= '0;
                ack_rng <= meas_rng;
            end
        end
    end

    // Timeout load handshake: latch once per request, acknowledge a cycle later.
    assign tvd_load = tvd_req && !tvd_ack_q && !tvd_load_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvd_load_q <= 1'b0;
            tvd_ack_q  <= 1'b0;
        end else begin
            tvd_load_q <= tvd_load;
            tvd_ack_q  <= tvd_req && (tvd_ack_q || tvd_load_q);
        end
    end

    assign freq_word   = freq_q;
    assign status_byte = {2'b00, ~hold_en, tvd_ack_q, 2'b00, ack_rng};

    // R5: a held result never moves
    a_r5_hold_freezes_result: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |=> $stable(freq_word));

    // R5: the range acknowledge never moves while held
    a_r5_hold_freezes_range: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |=> $stable(status_byte[1:0]));

    // R6: any reported value other than the marker is within the range limit
    a_r6_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_word != 32'hFFFF_FFFF) |->
        (64'(freq_word) <= 64'(MAX_HZ) * 64'(unit_scale(status_byte[1:0]))));

    // R8: timeout acknowledge drops once the request is withdrawn
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_byte[4] |=> !status_byte[4]);

    // R8: timeout acknowledge only rises under a standing request
    a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[4]) |-> $past(ctrl_byte[4]));

endmodule

// File: tb/test_period_freq_meter.sv
// Self-checking bench: behavioural frequency model plus per-clock monitor.
module test_period_freq_meter;

    localparam int unsigned CLK_HZ = 100_000;
    localparam int unsigned MAXHZ  = 10_000;
    localparam int unsigned WD_MS  = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sig_in = 1'b0;
    logic        hold_en;
    logic [7:0]  ctrl_byte;
    logic [15:0] wd_data;
    logic [7:0]  status_byte;
    logic [31:0] freq_word;

    int n_checks = 0;
    int n_fails  = 0;
    int gen_period = 0;
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    period_freq_meter #(
        .CLK_HZ        (CLK_HZ),
        .MAX_HZ        (MAXHZ),
        .WD_DEFAULT_MS (WD_MS)
    ) i_period_freq_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_in      (sig_in),
        .hold_en     (hold_en),
        .ctrl_byte   (ctrl_byte),
        .wd_data     (wd_data),
        .status_byte (status_byte),
        .freq_word   (freq_word)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural expectation for a range and an input period in reference cycles.
    function automatic logic [31:0] model_freq(input int rng, input int per);
        longint sc, n, u;
        sc = (rng == 0) ? 1000 : (rng == 1) ? 100 : (rng == 2) ? 10 : 1;
        n  = (rng == 0) ? 1 : (rng == 1) ? 4 : 16;
        u  = (sc * n * longint'(CLK_HZ)) / (n * per);
        if (u > longint'(MAXHZ) * sc) return 32'hFFFF_FFFF;
        return u[31:0];
    endfunction

    // Pulse source: square wave of gen_period cycles, low when zero.
    always begin
        if (gen_period > 0) begin
            sig_in = 1'b1;
            repeat (gen_period / 2) @(negedge clk);
            sig_in = 1'b0;
            repeat (gen_period - gen_period / 2) @(negedge clk);
        end else begin
            sig_in = 1'b0;
            @(negedge clk);
        end
    end

    // Per-clock monitor: reserved bits, hold flag, acknowledge model, hold freeze.
    logic        req_prev = 1'b0;
    logic [31:0] freq_prev = '0;
    always @(posedge clk) begin
        #2;
        if (mon_on && rst_n) begin
            chk("R10 reserved status bits", {24'd0, status_byte & 8'hCC}, 32'd0);
            chk("R5 hold flag in status", {31'd0, status_byte[5]}, {31'd0, !hold_en});
            chk("R8 timeout ack", {31'd0, status_byte[4]}, {31'd0, ctrl_byte[4] & req_prev});
            if (hold_en) chk("R5 result frozen", freq_word, freq_prev);
        end
        req_prev  = ctrl_byte[4];
        freq_prev = freq_word;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        rst_n = 1'b0; hold_en = 1'b0; ctrl_byte = 8'h00; wd_data = 16'h0000;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        mon_on = 1'b1;
        chk("R1 reset result", freq_word, 32'd0);
        chk("R1 reset status", {24'd0, status_byte}, 32'h20);

        gen_period = 50; wait_cyc(600);
        chk("R2 range 00 period 50", freq_word, model_freq(0, 50));
        gen_period = 37; wait_cyc(600);
        chk("R2 range 00 period 37", freq_word, model_freq(0, 37));

        ctrl_byte = 8'h01; wait_cyc(20);
        chk("R4 ack holds old range", {30'd0, status_byte[1:0]}, 32'd0);
        chk("R4 result holds old value", freq_word, model_freq(0, 37));
        wait_cyc(800);
        chk("R4 ack follows new range", {30'd0, status_byte[1:0]}, 32'd1);
        chk("R3 range 01 period 37", freq_word, model_freq(1, 37));

        ctrl_byte = 8'h02; gen_period = 50; wait_cyc(2500);
        chk("R3 range 10 ack", {30'd0, status_byte[1:0]}, 32'd2);
        chk("R3 range 10 period 50", freq_word, model_freq(2, 50));
        ctrl_byte = 8'h03; wait_cyc(2500);
        chk("R3 range 11 ack", {30'd0, status_byte[1:0]}, 32'd3);
        chk("R3 range 11 period 50", freq_word, model_freq(3, 50));

        hold_en = 1'b1; gen_period = 60; ctrl_byte = 8'h00; wait_cyc(1500);
        chk("R5 held result", freq_word, model_freq(3, 50));
        chk("R5 range request refused", {30'd0, status_byte[1:0]}, 32'd3);
        chk("R5 status shows held", {31'd0, status_byte[5]}, 32'd0);
        hold_en = 1'b0; wait_cyc(1);
        chk("R5 status shows released", {31'd0, status_byte[5]}, 32'd1);
        wait_cyc(600);
        chk("R5 request taken after release", {30'd0, status_byte[1:0]}, 32'd0);
        chk("R2 range 00 period 60", freq_word, model_freq(0, 60));

        gen_period = 10; wait_cyc(400);
        chk("R6 exactly at limit", freq_word, 32'd10_000_000);
        gen_period = 9; wait_cyc(400);
        chk("R6 just above limit", freq_word, 32'hFFFF_FFFF);
        gen_period = 6; wait_cyc(400);
        chk("R6 far above limit", freq_word, model_freq(0, 6));
        gen_period = 50; wait_cyc(400);
        chk("R6 recovers in range", freq_word, model_freq(0, 50));

        gen_period = 0; wait_cyc(1700);
        chk("R7 before default timeout", freq_word, model_freq(0, 50));
        wait_cyc(600);
        chk("R7 after default timeout", freq_word, 32'd0);
        gen_period = 50; wait_cyc(400);
        chk("R7 restart after silence", freq_word, model_freq(0, 50));

        wd_data = 16'hC005; ctrl_byte = 8'h10; wait_cyc(1);
        chk("R8 ack not yet set", {31'd0, status_byte[4]}, 32'd0);
        wait_cyc(1);
        chk("R8 ack set", {31'd0, status_byte[4]}, 32'd1);
        ctrl_byte = 8'h00; wait_cyc(1);
        chk("R8 ack cleared", {31'd0, status_byte[4]}, 32'd0);

        gen_period = 0; wait_cyc(300);
        chk("R9 before masked timeout", freq_word, model_freq(0, 50));
        wait_cyc(400);
        chk("R9 after masked 5 ms timeout", freq_word, 32'd0);

        finish_test();
    end

endmodule